// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable cell of a logic fabric. It holds a 16-bit lookup table and a storage element, and a static configuration word decides how they are used. In general-logic mode the table computes any function of four data lines. In arithmetic mode the table is split into two 3-input halves: one gives the result bit and the other gives the carry sent to the next cell. In counting mode the same two halves produce the next count bit and the ripple carry. Data lines then act as load value, count enable, direction and load strobe.

Cells are chained through two paths. The carry path links cells into adders and counters. The cascade path merges the table outputs of neighbouring cells with AND or OR, so that each added cell makes the function four inputs wider. The storage element can behave as a D, T, JK or SR flip-flop, or it can be skipped so that the result is purely combinational. Asynchronous clear and preset force the stored bit. The configuration word is captured only while the synchronous reset is held.

Top module: `logic_cell`

## Requirements
- R1: In general-logic mode (mode field cfg_word[17:16] = 00 or 11) the table output is cfg_word[{din[3],din[2],din[1],din[0]}], with din[0] as the least significant index bit.
- R2: In arithmetic mode (mode 01) the index is {carry_in, din[1], din[0]}. The function value is cfg_word[index] and carry_out is cfg_word[8+index]. Four chained cells with the sum and majority tables form a 4-bit adder.
- R3: In general-logic mode the function value is the table output ANDed with casc_in when cfg_word[21] = 0, and ORed with casc_in when cfg_word[21] = 1. casc_out carries this value. In other modes casc_out equals casc_in. Chained cells compute a 16-input AND or OR.
- R4: In counting mode (mode 10), din[3]=1 loads din[0] at the next clock edge. Otherwise din[1]=1 loads cfg_word[{din[2],carry_in,q}], and din[1]=0 holds the bit. carry_out is cfg_word[8+{din[2],carry_in,q}]. The flip-flop type is ignored and the result is always the stored bit.
- R5: The flip-flop type field cfg_word[20:18] selects the next-state rule for function value v. 0 gives D (v). 1 gives T (toggle when v=1). 2 gives JK (J=v, K=din[3]). 3 gives SR (S=v, R=din[3], with R taking priority).
- R6: Type codes 4 to 7 outside counting mode bypass the storage element, and result follows the function value in the same cycle. Otherwise result is the stored bit.
- R7: clr and pre are active-high and asynchronous. clr forces the stored bit to 0 and pre forces it to 1. When both are high, clr wins.
- R8: While rst_n is low at a rising clock edge, the stored bit becomes 0 and cfg_word is captured. Changes on cfg_word while rst_n is high have no effect.
- R9: carry_out is 0 in general-logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration capture window |
| cfg_word | input | 22 | Configuration: table [15:0], mode [17:16], flip-flop type [20:18], cascade OR [21] |
| din | input | 4 | Data lines |
| carry_in | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade value from the previous cell |
| clr | input | 1 | Asynchronous clear, active high |
| pre | input | 1 | Asynchronous preset, active high |
| result | output | 1 | Combinational or stored result |
| carry_out | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade value to the next cell |

## Verification
carry_out and casc_out, along with result in bypass, are combinational. They are due in the same cycle as the inputs that feed them. The stored result is due one rising edge after its inputs, and clr or pre act at once without waiting for a clock. A new configuration takes effect only after a clock edge with rst_n low. The bench drives every input on the falling edge and compares all three outputs against its reference on the following falling edge. The combinational chain tests settle for one nanosecond before comparing.

// File: rtl/lcell_pkg.sv
// Shared sizing and encodings for the configurable logic cell.
// Assumes a 4-input table; counting mode uses data lines 0..3 as named below.
package lcell_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    parameter int LUT_IN = 4;
    localparam int LUT_BITS  = 1 << LUT_IN;
    localparam int HALF_BITS = LUT_BITS / 2;
    localparam int FF_W      = 3;
    localparam int MODE_W    = 2;
    localparam int CFG_W     = LUT_BITS + MODE_W + FF_W + 1;

    // operating modes
    localparam logic [MODE_W-1:0] MD_LOGIC = 2'b00;
    localparam logic [MODE_W-1:0] MD_ARITH = 2'b01;
    localparam logic [MODE_W-1:0] MD_COUNT = 2'b10;

    // storage element behaviours (codes 4..7 bypass)
    localparam logic [FF_W-1:0] FF_D  = 3'd0;
    localparam logic [FF_W-1:0] FF_T  = 3'd1;
    localparam logic [FF_W-1:0] FF_JK = 3'd2;
    localparam logic [FF_W-1:0] FF_SR = 3'd3;

    // data line roles in counting mode and for the second flip-flop input
    localparam int LN_DATA = 0;
    localparam int LN_EN   = 1;
    localparam int LN_UP   = 2;
    localparam int LN_LOAD = 3;
    localparam int LN_K    = 3;

    typedef struct packed {
        logic                  casc_or;
        logic [FF_W-1:0]       ff_sel;
        logic [MODE_W-1:0]     mode;
        logic [LUT_BITS-1:0]   mask;
    } cfg_t;
endpackage

// File: rtl/lcell_func.sv
// Combinational part of the cell: full table, split sum/carry tables,
// counter next-bit logic and the cascade merge.
// Assumes mask, mode and casc_or are static outside reset.
module lcell_func
    import lcell_pkg::*;
(
    input  logic [LUT_BITS-1:0] mask,
    input  logic [MODE_W-1:0]   mode,
    input  logic                casc_or,
    input  logic [LUT_IN-1:0]   din,
    input  logic                carry_in,
    input  logic                casc_in,
    input  logic                q_fb,
    output logic                fval,
    output logic                carry_out,
    output logic                casc_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [HALF_BITS-1:0] sum_tab;
    logic [HALF_BITS-1:0] cy_tab;
    logic [LUT_IN-2:0]    ar_idx;
    logic [LUT_IN-2:0]    ct_idx;
    logic                 full_bit;

    assign sum_tab  = mask[HALF_BITS-1:0];
    assign cy_tab   = mask[LUT_BITS-1:HALF_BITS];
    assign ar_idx   = {carry_in, din[LUT_IN-3:0]};
    assign ct_idx   = {din[LN_UP], carry_in, q_fb};
    assign full_bit = mask[din];

    // Select the function value and chain outputs for the active mode.
    always_comb begin
        fval      = full_bit;
        carry_out = 1'b0;
        casc_out  = casc_in;
        case (mode)
            MD_ARITH: begin
                fval      = sum_tab[ar_idx];
                carry_out = cy_tab[ar_idx];
            end
            MD_COUNT: begin
                carry_out = cy_tab[ct_idx];
                if (din[LN_LOAD])
                    fval = din[LN_DATA];
                else if (din[LN_EN])
                    fval = sum_tab[ct_idx];
                else
                    fval = q_fb;
            end
            default: begin
                if (casc_or)
                    fval = ~(~full_bit & ~casc_in);
                else
                    fval = full_bit & casc_in;
                casc_out = fval;
            end
        endcase
    end
endmodule

// File: rtl/lcell_reg.sv
// Storage element of the cell with selectable D/T/JK/SR behaviour.
// Assumes clr/pre are asynchronous active-high (clr first) and rst_n is
// a synchronous active-low reset to 0.
module lcell_reg
    import lcell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            pre,
    input  logic [FF_W-1:0] ff_sel,
    input  logic            counting,
    input  logic            d_in,
    input  logic            k_in,
    output logic            q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic nxt;

    // Next-state rule for the configured flip-flop behaviour.
    always_comb begin
        if (counting) begin
            nxt = d_in;
        end else begin
            case (ff_sel)
                FF_T:  nxt = q ^ d_in;
                FF_JK: begin
                    case ({d_in, k_in})
                        2'b10:   nxt = 1'b1;
                        2'b01:   nxt = 1'b0;
                        2'b11:   nxt = ~q;
                        default: nxt = q;
                    endcase
                end
                FF_SR: nxt = k_in ? 1'b0 : (d_in ? 1'b1 : q);
                default: nxt = d_in;
            endcase
        end
    end

    // State update: async clear/preset over sync reset over next state.
    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr)
            q <= 1'b0;
        else if (pre)
            q <= 1'b1;
        else if (!rst_n)
            q <= 1'b0;
        else
            q <= nxt;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (q == 1'b0)); // R7
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr) |-> (q == 1'b1)); // R7
    AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n || clr || pre)
        (!counting && ff_sel == FF_JK && d_in && k_in) |=> (q == !$past(q))); // R5
endmodule

// File: rtl/logic_cell.sv
// Top of the configurable logic cell. Captures the configuration word
// while rst_n is low and joins the function logic to the storage element.
// Assumes cfg_word is only meaningful during reset.
module logic_cell
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [LUT_IN-1:0] din,
    input  logic             carry_in,
    input  logic             casc_in,
    input  logic             clr,
    input  logic             pre,
    output logic             result,
    output logic             carry_out,
    output logic             casc_out
);
    timeunit 1ns;
    timeprecision 1ps;

    cfg_t cfg_q;
    logic fval;
    logic q;
    logic counting;
    logic pass;

    // Configuration capture, open only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= cfg_t'(cfg_word);
    end

    assign counting = (cfg_q.mode == MD_COUNT);
    assign pass     = cfg_q.ff_sel[FF_W-1] && !counting;

    lcell_func u_func (
        .mask      (cfg_q.mask),
        .mode      (cfg_q.mode),
        .casc_or   (cfg_q.casc_or),
        .din       (din),
        .carry_in  (carry_in),
        .casc_in   (casc_in),
        .q_fb      (q),
        .fval      (fval),
        .carry_out (carry_out),
        .casc_out  (casc_out)
    );

    lcell_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .pre      (pre),
        .ff_sel   (cfg_q.ff_sel),
        .counting (counting),
        .d_in     (fval),
        .k_in     (din[LN_K]),
        .q        (q)
    );

    // Output select: bypassed function value or stored bit.
    assign result = pass ? fval : q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q)); // R8
    AST_CASC_AND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.mode[0] && !counting && !cfg_q.casc_or && !casc_in) |-> !casc_out); // R3
    AST_NO_CARRY_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MD_LOGIC) |-> !carry_out); // R9
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || clr || pre)
        (counting && din[LN_LOAD]) |=> (result == $past(din[LN_DATA]))); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr || pre)
        (counting && !din[LN_LOAD] && !din[LN_EN]) |=> $stable(result)); // R4
endmodule

// File: tb/tb_logic_cell.sv
// Self-checking bench: behavioural reference compared every cycle for a
// single cell, plus four chained cells for an adder and wide AND/OR.
module tb_logic_cell;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 4;
    localparam int CW  = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic [3:0] din = '0;
    logic cin = 1'b0, cas = 1'b1, clr = 1'b0, pre = 1'b0;
    wire  result, cout, cas_out;

    logic [CW-1:0] ch_cfg = '0;
    logic [4*NCH-1:0] ch_d = '0;
    logic ch_c0 = 1'b0, ch_k0 = 1'b1;
    wire [NCH:0] ch_c, ch_k;
    wire [NCH-1:0] ch_r;
    assign ch_c[0] = ch_c0;
    assign ch_k[0] = ch_k0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    logic_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .din(din),
        .carry_in(cin), .casc_in(cas), .clr(clr), .pre(pre),
        .result(result), .carry_out(cout), .casc_out(cas_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic_cell chain (
            .clk(clk), .rst_n(rst_n), .cfg_word(ch_cfg), .din(ch_d[4*i +: 4]),
            .carry_in(ch_c[i]), .casc_in(ch_k[i]), .clr(1'b0), .pre(1'b0),
            .result(ch_r[i]), .carry_out(ch_c[i+1]), .casc_out(ch_k[i+1])
        );
    end

    // ---------------- reference model ----------------
    logic [CW-1:0] m_cfg;
    logic m_q;

    function automatic logic ref_f(input logic [CW-1:0] c, input logic [3:0] d,
                                   input logic ci, input logic ca, input logic q);
        logic [15:0] m;
        int idx;
        m = c[15:0];
        case (c[17:16])
            2'd1: begin
                idx = ci * 4 + d[1] * 2 + d[0];
                return m[idx];
            end
            2'd2: begin
                if (d[3]) return d[0];
                if (!d[1]) return q;
                idx = d[2] * 4 + ci * 2 + q;
                return m[idx];
            end
            default: begin
                idx = d;
                if (c[21]) return m[idx] | ca;
                return m[idx] & ca;
            end
        endcase
    endfunction

    function automatic logic ref_next(input logic [CW-1:0] c, input logic [3:0] d,
                                      input logic ci, input logic ca, input logic q);
        logic v;
        v = ref_f(c, d, ci, ca, q);
        if (c[17:16] == 2'd2) return v;
        case (c[20:18])
            3'd1: return v ? ~q : q;
            3'd2: begin
                if (v && d[3]) return ~q;
                if (v) return 1'b1;
                if (d[3]) return 1'b0;
                return q;
            end
            3'd3: begin
                if (d[3]) return 1'b0;
                if (v) return 1'b1;
                return q;
            end
            default: return v;
        endcase
    endfunction

    // Capture configuration under reset.
    always @(posedge clk) begin
        if (!rst_n) m_cfg <= cfg_word;
    end

    // Stored bit with asynchronous clear/preset.
    always @(posedge clk or posedge clr or posedge pre) begin
        if (clr) m_q <= 1'b0;
        else if (pre) m_q <= 1'b1;
        else if (!rst_n) m_q <= 1'b0;
        else m_q <= ref_next(m_cfg, din, cin, cas, m_q);
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic v, er, ec, ek;
        int md, idx;
        md = m_cfg[17:16];
        v  = ref_f(m_cfg, din, cin, cas, m_q);
        er = (md == 2 || m_cfg[20] == 1'b0) ? m_q : v;
        if (md == 1) begin
            idx = 8 + cin * 4 + din[1] * 2 + din[0];
            ec = m_cfg[idx];
        end else if (md == 2) begin
            idx = 8 + din[2] * 4 + cin * 2 + m_q;
            ec = m_cfg[idx];
        end else begin
            ec = 1'b0;
        end
        ek = (md == 0 || md == 3) ? v : cas;
        chk((clr || pre) ? "R7" : tag, {7'd0, result}, {7'd0, er});
        chk((md == 0) ? "R9" : tag, {7'd0, cout}, {7'd0, ec});
        chk("R3", {7'd0, cas_out}, {7'd0, ek});
    endtask

    // Reset with a configuration, then random stimulus compared every cycle.
    task automatic run_phase(input string tag, input logic [CW-1:0] c, input int n,
                             input bit async_on);
        rst_n = 1'b0; cfg_word = c; clr = 1'b0; pre = 1'b0;
        din = '0; cin = 1'b0; cas = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R8");
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            din      = 4'($urandom);
            cin      = 1'($urandom);
            cas      = 1'($urandom);
            cfg_word = CW'($urandom);
            clr      = async_on && ($urandom % 12 == 0);
            pre      = async_on && ($urandom % 10 == 0);
            @(negedge clk);
            check_all(tag);
        end
        clr = 1'b0; pre = 1'b0;
    endtask

    task automatic chain_reset(input logic [CW-1:0] c);
        ch_cfg = c;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: general logic, D storage, cascade AND
        run_phase("R1", {1'b0, 3'd0, 2'd0, 16'hA5C3}, 300, 1'b0);
        // R3: cascade OR, alternate general-logic code 11
        run_phase("R3", {1'b1, 3'd0, 2'd3, 16'h1E68}, 200, 1'b0);
        // R5: T, JK, SR behaviours
        run_phase("R5", {1'b0, 3'd1, 2'd0, 16'h6996}, 200, 1'b0);
        run_phase("R5", {1'b1, 3'd2, 2'd0, 16'h35CA}, 300, 1'b0);
        run_phase("R5", {1'b0, 3'd3, 2'd0, 16'hF0F0}, 300, 1'b0);
        // R6: bypass codes
        run_phase("R6", {1'b0, 3'd4, 2'd0, 16'h8E17}, 200, 1'b0);
        run_phase("R6", {1'b1, 3'd7, 2'd1, 16'hE896}, 200, 1'b0);
        // R2: arithmetic with D storage
        run_phase("R2", {1'b0, 3'd0, 2'd1, 16'hE896}, 200, 1'b0);
        // R4: counting with up/down tables, type field set to bypass (ignored)
        run_phase("R4", {1'b0, 3'd5, 2'd2, 16'h4866}, 300, 1'b0);
        // R7: asynchronous clear and preset
        run_phase("R7", {1'b0, 3'd0, 2'd0, 16'h7BDE}, 300, 1'b1);
        run_phase("R7", {1'b0, 3'd1, 2'd2, 16'h4866}, 300, 1'b1);
        // R8: random configuration traffic after reset
        run_phase("R8", {1'b0, 3'd2, 2'd1, 16'h17E8}, 200, 1'b0);

        // R2: four-cell ripple adder, storage bypassed
        chain_reset({1'b0, 3'd4, 2'd1, 16'hE896});
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    int s;
                    for (int i = 0; i < NCH; i++)
                        ch_d[4*i +: 4] = {2'b00, 1'(b >> i), 1'(a >> i)};
                    ch_c0 = 1'(c);
                    #1;
                    s = a + b + c;
                    chk("R2", {3'd0, ch_c[NCH], ch_r}, 8'(s));
                end
            end
        end
        ch_c0 = 1'b0;

        // R3: 16-input AND through the cascade chain
        chain_reset({1'b0, 3'd4, 2'd0, 16'h8000});
        ch_k0 = 1'b1;
        ch_d = 16'hFFFF; #1;
        chk("R3", {7'd0, ch_r[NCH-1]}, 8'd1);
        for (int k = 0; k < 16; k++) begin
            ch_d = ~(16'd1 << k); #1;
            chk("R3", {7'd0, ch_r[NCH-1]}, 8'd0);
        end

        // R3: 16-input OR through the cascade chain
        chain_reset({1'b1, 3'd4, 2'd0, 16'hFFFE});
        ch_k0 = 1'b0;
        ch_d = 16'h0000; #1;
        chk("R3", {7'd0, ch_r[NCH-1]}, 8'd0);
        for (int k = 0; k < 16; k++) begin
            ch_d = 16'd1 << k; #1;
            chk("R3", {7'd0, ch_r[NCH-1]}, 8'd1);
        end

        finish_run();
    end
endmodule